// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block takes received Ethernet frames from a byte-wide receive FIFO and places them into memory buffers that software posts through a ring of descriptors. Each descriptor is two 32-bit words in memory. The first word carries control and status, and the second word holds the buffer address. The engine reads the control word at its current ring index. If the engine does not own that descriptor, it waits for a kick pulse from software and then polls the same index again. Once it owns a descriptor, it reads the buffer address and starts accepting bytes.

Bytes are packed into little-endian 32-bit words. The words collect in a small burst buffer and go out as bursts of at most 16 words over a simple request/grant memory port. When the frame ends, the engine writes a single status word back into the descriptor. That word carries the received byte count, the packet boundary flags, the copied wrap flag and the error bits, and it clears the ownership flag. The engine then moves to the next index, or returns to index 0 if the descriptor carried the wrap flag. A one-cycle completion interrupt follows every write-back, and an error interrupt accompanies it when the frame had an error.

Top module: `rxdma_ring_engine`

## Requirements
- R1: Descriptor i sits at ring_base + 8*i. The control word is at offset 0 and the buffer address at offset 4. After reset the first access is a read of ring_base. A memory request that has not been granted holds its address, direction and data unchanged.
- R2: If bit 15 (ownership) of a fetched control word is 0, the engine makes no further memory request until a kick pulse arrives. It then reads the same control word again, without skipping ahead.
- R3: Frame bytes are written little-endian, with byte 4k+j in bits 8j+7:8j of the word at buffer address + 4k. Unused high bytes of the final word are zero.
- R4: Data words go out in bursts of at most BURST_WORDS (16) words. mem_burst_first marks the first word of each burst, and mem_burst_len then equals the number of words in that burst: the lesser of 16 and the words still to be written.
- R5: The written-back control word holds the received byte count in bits 27:16, saturated at 4095. It also has bit 15 = 0, bit 14 = 1 (end of packet), bit 13 = 1 (start of packet) and bit 12 equal to the fetched wrap flag.
- R6: The error flags sampled with the last byte map to the written-back word as follows: fifo_err[0] to bit 0 (FIFO overflow), fifo_err[1] to bit 1 (CRC), fifo_err[2] to bit 2 (symbol) and fifo_err[3] to bit 9 (underrun). Bits 3, 5 to 8 and 31:28 are zero.
- R7: Bit 4 (oversize) is set exactly when the byte count exceeds MAX_FRAME (2046), including frames of 2048 bytes and longer.
- R8: After the write-back of a descriptor whose bit 12 was set, the next fetch is at index 0. Otherwise it is at the following index.
- R9: Bytes beyond BUF_BYTES within a frame are counted but not written to memory.
- R10: irq_done is a one-cycle pulse after each write-back. irq_err pulses together with it if and only if any of bits 0, 1, 2, 4 or 9 of the written-back word is set.
- R11: fifo_ready is high only while the engine is accepting frame bytes, and it is never high together with mem_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | 32 | Byte address of ring index 0 |
| kick | input | 1 | Software pulse: re-poll a descriptor that was not owned |
| fifo_valid | input | 1 | Receive FIFO byte valid |
| fifo_data | input | 8 | Receive FIFO byte |
| fifo_last | input | 1 | Byte is the last of its frame |
| fifo_err | input | 4 | Frame error flags, valid with the last byte |
| fifo_ready | output | 1 | Engine accepts a byte this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with grant |
| mem_gnt | input | 1 | Access completes this cycle |
| mem_burst_first | output | 1 | First word of a data burst |
| mem_burst_len | output | BL_W | Words in the current data burst |
| irq_done | output | 1 | Frame write-back pulse |
| irq_err | output | 1 | Errored-frame pulse |

## Verification
Frame lengths from 1 to 40 bytes cover every residue modulo 4. These show whether byte packing, zero fill of the last word and the remainder burst are right. The error flag pattern follows the length, so all sixteen flag combinations reach the status word. Lengths near the buffer capacity and the 16-word burst edge separate truncation from burst splitting. Lengths of 2045 to 2048 and 4095 to 4200 tell the oversize threshold apart from length saturation. A ring of four descriptors, with the wrap flag on the last one and the first one posted late, exercises the stall, kick and return-to-zero paths. Grants are withheld every third cycle so that held requests are exercised.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

  localparam int LEN_W    = 12;
  localparam int LEN_LSB  = 16;
  localparam int OWN_BIT  = 15;
  localparam int EOP_BIT  = 14;
  localparam int SOP_BIT  = 13;
  localparam int WRAP_BIT = 12;
  localparam int ERR_OVF  = 0;
  localparam int ERR_CRC  = 1;
  localparam int ERR_SYM  = 2;
  localparam int ERR_OVSZ = 4;
  localparam int ERR_UNDR = 9;

  localparam logic [31:0] ERR_MASK =
    (32'd1 << ERR_OVF) | (32'd1 << ERR_CRC) | (32'd1 << ERR_SYM) |
    (32'd1 << ERR_OVSZ) | (32'd1 << ERR_UNDR);

  typedef enum logic [2:0] {
    ST_FETCH_CTL,
    ST_FETCH_PTR,
    ST_STALL,
    ST_RECV,
    ST_BURST,
    ST_WBACK
  } rx_state_e;

  typedef struct packed {
    logic underrun;
    logic symbol;
    logic crc;
    logic overflow;
  } rx_err_t;

  // saturating byte counter step
  function automatic logic [LEN_W-1:0] sat_inc(input logic [LEN_W-1:0] c);
    return (c == {LEN_W{1'b1}}) ? c : c + 1'b1;
  endfunction

  // assemble the written-back control/status word
  function automatic logic [31:0] pack_status(input logic [LEN_W-1:0] len,
                                              input rx_err_t err,
                                              input logic oversize,
                                              input logic wrap);
    logic [31:0] w;
    w = '0;
    w[LEN_LSB +: LEN_W] = len;
    w[EOP_BIT]  = 1'b1;
    w[SOP_BIT]  = 1'b1;
    w[WRAP_BIT] = wrap;
    w[ERR_OVF]  = err.overflow;
    w[ERR_CRC]  = err.crc;
    w[ERR_SYM]  = err.symbol;
    w[ERR_OVSZ] = oversize;
    w[ERR_UNDR] = err.underrun;
    return w;
  endfunction

endpackage

// File: rtl/rxdma_byte_packer.sv
module rxdma_byte_packer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accept,
  input  logic [7:0]  byte_in,
  input  logic        last_in,
  output logic        word_fire,
  output logic [31:0] word_out
);
  logic [1:0]  pos;
  logic [23:0] acc;

  always_comb begin
    word_out  = {8'h00, acc} | ({24'h0, byte_in} << {pos, 3'b000});
    word_fire = accept && ((pos == 2'd3) || last_in);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0;
      acc <= '0;
    end else if (accept) begin
      if (word_fire) begin
        pos <= '0;
        acc <= '0;
      end else begin
        pos <= pos + 2'd1;
        acc <= word_out[23:0];
      end
    end
  end
endmodule

// File: rtl/rxdma_burst_buf.sv
module rxdma_burst_buf #(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [31:0]      push_word,
  input  logic             pop,
  output logic [CNT_W-1:0] fill,
  output logic [CNT_W-1:0] rd_ptr,
  output logic [31:0]      head,
  output logic             full,
  output logic             drained
);
  logic [31:0] store [DEPTH];

  assign full    = (int'(fill) == DEPTH);
  assign head    = store[rd_ptr[PTR_W-1:0]];
  assign drained = pop && (rd_ptr == fill - 1'b1);

  always_ff @(posedge clk) begin
    if (push && !full) store[fill[PTR_W-1:0]] <= push_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill   <= '0;
      rd_ptr <= '0;
    end else if (drained) begin
      fill   <= '0;
      rd_ptr <= '0;
    end else if (pop) begin
      rd_ptr <= rd_ptr + 1'b1;
    end else if (push && !full) begin
      fill <= fill + 1'b1;
    end
  end
endmodule

// File: rtl/rxdma_ring_idx.sv
module rxdma_ring_idx #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      ring_base,
  input  logic             advance,
  input  logic             wrap,
  output logic [IDX_W-1:0] idx,
  output logic [31:0]      desc_addr
);
  assign desc_addr = ring_base + (32'(idx) << 3);

  always_ff @(posedge clk) begin
    if (!rst_n)       idx <= '0;
    else if (advance) idx <= wrap ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/rxdma_ring_engine.sv
module rxdma_ring_engine
  import rxdma_pkg::*;
#(
  parameter int RING_IDX_W  = 6,
  parameter int BURST_WORDS = 16,
  parameter int BUF_BYTES   = 2048,
  parameter int MAX_FRAME   = 2046
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ring_base,
  input  logic        kick,
  input  logic        fifo_valid,
  input  logic [7:0]  fifo_data,
  input  logic        fifo_last,
  input  logic [3:0]  fifo_err,
  output logic        fifo_ready,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_gnt,
  output logic        mem_burst_first,
  output logic [$clog2(BURST_WORDS+1)-1:0] mem_burst_len,
  output logic        irq_done,
  output logic        irq_err
);
  localparam int BUF_WORDS = BUF_BYTES / 4;
  localparam int WCNT_W    = $clog2(BUF_WORDS + 1);
  localparam int BL_W      = $clog2(BURST_WORDS + 1);

  rx_state_e         state, state_nx;
  logic [31:0]       buf_addr;
  logic              wrap_q;
  logic [LEN_W-1:0]  bcnt;
  logic [WCNT_W-1:0] wcount, burst_base;
  rx_err_t           err_q;
  logic              frame_done;

  logic [RING_IDX_W-1:0] desc_idx;
  logic [31:0]       desc_addr;
  logic              accept, word_fire, push, pop, drained, full, room;
  logic [31:0]       word_data, head, status_word, data_addr;
  logic [BL_W-1:0]   fill, rd_ptr;
  logic              oversize;

  // named internal events
  logic ev_fetch_ok, ev_not_owned, ev_ptr_taken, ev_wback;
  logic receiving, stalled;

  assign receiving    = (state == ST_RECV);
  assign stalled      = (state == ST_STALL);
  assign ev_fetch_ok  = (state == ST_FETCH_CTL) && mem_gnt && mem_rdata[OWN_BIT];
  assign ev_not_owned = (state == ST_FETCH_CTL) && mem_gnt && !mem_rdata[OWN_BIT];
  assign ev_ptr_taken = (state == ST_FETCH_PTR) && mem_gnt;
  assign ev_wback     = (state == ST_WBACK) && mem_gnt;

  assign fifo_ready = receiving && !full;
  assign accept     = fifo_valid && fifo_ready;
  assign room       = int'(wcount) < BUF_WORDS;
  assign push       = word_fire && room;
  assign pop        = (state == ST_BURST) && mem_gnt;
  assign oversize   = int'(bcnt) > MAX_FRAME;
  assign status_word = pack_status(bcnt, err_q, oversize, wrap_q);
  assign data_addr  = buf_addr + ((32'(burst_base) + 32'(rd_ptr)) << 2);

  rxdma_byte_packer u_packer (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .byte_in   (fifo_data),
    .last_in   (fifo_last),
    .word_fire (word_fire),
    .word_out  (word_data)
  );

  rxdma_burst_buf #(.DEPTH(BURST_WORDS)) u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_word (word_data),
    .pop       (pop),
    .fill      (fill),
    .rd_ptr    (rd_ptr),
    .head      (head),
    .full      (full),
    .drained   (drained)
  );

  rxdma_ring_idx #(.IDX_W(RING_IDX_W)) u_idx (
    .clk       (clk),
    .rst_n     (rst_n),
    .ring_base (ring_base),
    .advance   (ev_wback),
    .wrap      (wrap_q),
    .idx       (desc_idx),
    .desc_addr (desc_addr)
  );

  // memory port drive
  always_comb begin
    mem_req         = 1'b0;
    mem_we          = 1'b0;
    mem_addr        = desc_addr;
    mem_wdata       = '0;
    mem_burst_first = 1'b0;
    mem_burst_len   = '0;
    unique case (state)
      ST_FETCH_CTL: mem_req = 1'b1;
      ST_FETCH_PTR: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + 32'd4;
      end
      ST_BURST: begin
        mem_req         = 1'b1;
        mem_we          = 1'b1;
        mem_addr        = data_addr;
        mem_wdata       = head;
        mem_burst_first = (rd_ptr == '0);
        mem_burst_len   = fill;
      end
      ST_WBACK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = status_word;
      end
      default: ;
    endcase
  end

  // next state
  always_comb begin
    state_nx = state;
    unique case (state)
      ST_FETCH_CTL: begin
        if (ev_fetch_ok)       state_nx = ST_FETCH_PTR;
        else if (ev_not_owned) state_nx = ST_STALL;
      end
      ST_STALL:     if (kick) state_nx = ST_FETCH_CTL;
      ST_FETCH_PTR: if (ev_ptr_taken) state_nx = ST_RECV;
      ST_RECV: begin
        if (accept && fifo_last)
          state_nx = (push || fill != '0) ? ST_BURST : ST_WBACK;
        else if (push && (int'(fill) + 1 == BURST_WORDS))
          state_nx = ST_BURST;
      end
      ST_BURST:     if (drained) state_nx = frame_done ? ST_WBACK : ST_RECV;
      ST_WBACK:     if (ev_wback) state_nx = ST_FETCH_CTL;
      default:      state_nx = ST_FETCH_CTL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_FETCH_CTL;
      buf_addr   <= '0;
      wrap_q     <= 1'b0;
      bcnt       <= '0;
      wcount     <= '0;
      burst_base <= '0;
      err_q      <= '0;
      frame_done <= 1'b0;
      irq_done   <= 1'b0;
      irq_err    <= 1'b0;
    end else begin
      state    <= state_nx;
      irq_done <= ev_wback;
      irq_err  <= ev_wback && |(status_word & ERR_MASK);
      if (ev_fetch_ok) wrap_q <= mem_rdata[WRAP_BIT];
      if (ev_ptr_taken) begin
        buf_addr   <= mem_rdata;
        bcnt       <= '0;
        wcount     <= '0;
        burst_base <= '0;
        err_q      <= '0;
        frame_done <= 1'b0;
      end
      if (accept) begin
        bcnt <= sat_inc(bcnt);
        if (fifo_last) begin
          err_q      <= rx_err_t'(fifo_err);
          frame_done <= 1'b1;
        end
      end
      if (push) wcount <= wcount + 1'b1;
      if (drained) burst_base <= burst_base + WCNT_W'(fill);
    end
  end
endmodule

// File: rtl/rxdma_ring_engine_chk.sv
module rxdma_ring_engine_chk #(
  parameter int RING_IDX_W  = 6,
  parameter int BURST_WORDS = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        kick,
  input logic        fifo_ready,
  input logic        receiving,
  input logic        stalled,
  input logic        ev_not_owned,
  input logic        ev_wback,
  input logic        wrap_q,
  input logic [RING_IDX_W-1:0] desc_idx,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_gnt,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_burst_first,
  input logic [$clog2(BURST_WORDS+1)-1:0] mem_burst_len,
  input logic        irq_done,
  input logic        irq_err
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R1

  AST_NOT_OWNED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_not_owned |=> !mem_req); // R2

  AST_STALL_WAITS_KICK: assert property (@(posedge clk) disable iff (!rst_n)
    stalled && !kick |=> !mem_req); // R2

  AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_burst_first |-> mem_we && mem_burst_len != '0 && int'(mem_burst_len) <= BURST_WORDS); // R4

  AST_OWN_RETURNED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wback |-> !mem_wdata[15] && mem_wdata[14] && mem_wdata[13] && mem_wdata[12] == wrap_q); // R5

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wback && wrap_q |=> desc_idx == '0); // R8

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wback && !wrap_q |=> desc_idx == $past(desc_idx) + 1'b1); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |=> !irq_done); // R10

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> irq_done); // R10

  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ready |-> receiving && !mem_req); // R11
endmodule

bind rxdma_ring_engine rxdma_ring_engine_chk #(
  .RING_IDX_W  (RING_IDX_W),
  .BURST_WORDS (BURST_WORDS)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .kick            (kick),
  .fifo_ready      (fifo_ready),
  .receiving       (receiving),
  .stalled         (stalled),
  .ev_not_owned    (ev_not_owned),
  .ev_wback        (ev_wback),
  .wrap_q          (wrap_q),
  .desc_idx        (desc_idx),
  .mem_req         (mem_req),
  .mem_we          (mem_we),
  .mem_gnt         (mem_gnt),
  .mem_addr        (mem_addr),
  .mem_wdata       (mem_wdata),
  .mem_burst_first (mem_burst_first),
  .mem_burst_len   (mem_burst_len),
  .irq_done        (irq_done),
  .irq_err         (irq_err)
);

// File: tb/test_rxdma_ring_engine.sv
module test_rxdma_ring_engine;
  localparam int BUF_BYTES = 128;
  localparam int BUF_WORDS = BUF_BYTES / 4;
  localparam int BURST     = 16;
  localparam int MAXF      = 2046;
  localparam int RING_N    = 4;
  localparam logic [31:0] DESC_BASE = 32'h0000_1000;
  localparam logic [31:0] BUF_BASE  = 32'h0001_0000;
  localparam logic [31:0] OWN  = 32'h0000_8000;
  localparam logic [31:0] WRAP = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] ring_base = DESC_BASE;
  logic kick = 1'b0;
  logic fifo_valid = 1'b0;
  logic [7:0] fifo_data = '0;
  logic fifo_last = 1'b0;
  logic [3:0] fifo_err = '0;
  logic fifo_ready;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic mem_gnt = 1'b0;
  logic mem_burst_first;
  logic [4:0] mem_burst_len;
  logic irq_done, irq_err;

  always #10 clk = ~clk;

  rxdma_ring_engine #(.BUF_BYTES(BUF_BYTES)) i_rxdma_ring_engine (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .kick(kick),
    .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_last(fifo_last),
    .fifo_err(fifo_err), .fifo_ready(fifo_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_gnt(mem_gnt),
    .mem_burst_first(mem_burst_first), .mem_burst_len(mem_burst_len),
    .irq_done(irq_done), .irq_err(irq_err)
  );

  bit [31:0] mem [bit [31:0]];
  int checks = 0;
  int errors = 0;
  int gcnt = 0;
  int rd_count = 0;
  int words_left = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'hDEAD_BEEF;
  endfunction

  function automatic logic [7:0] bval(input int len, input int i);
    return 8'(len * 3 + i * 5 + 1);
  endfunction

  // memory model: grant two cycles of three, writes land at the next edge
  always @(negedge clk) begin
    bit g;
    gcnt++;
    g = (gcnt % 3) != 2;
    mem_gnt = g;
    mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
    if (rst_n && mem_req && g) begin
      if (!mem_we) rd_count++;
      else begin
        if (mem_addr >= BUF_BASE) begin
          if (mem_burst_first) begin
            int e;
            e = (words_left > BURST) ? BURST : words_left;
            chk(int'(mem_burst_len) == e, "R4", "burst length", 32'(mem_burst_len), 32'(e));
          end
          words_left--;
        end
        mem[mem_addr] = mem_wdata;
      end
    end
  end

  task automatic arm(input int i, input bit owned);
    mem[DESC_BASE + 32'(8 * i)]     = (owned ? OWN : 32'h0) | ((i == RING_N - 1) ? WRAP : 32'h0);
    mem[DESC_BASE + 32'(8 * i) + 4] = BUF_BASE + 32'(i * 32'h1000);
  endtask

  task automatic run_frame(input int len, input logic [3:0] e, input int idx);
    int t;
    int nw;
    logic [31:0] st, exp_err, b;
    int bad;
    nw = (len + 3) / 4;
    if (nw > BUF_WORDS) nw = BUF_WORDS;
    words_left = nw;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      fifo_valid = 1'b1;
      fifo_data  = bval(len, i);
      fifo_last  = (i == len - 1);
      fifo_err   = (i == len - 1) ? e : 4'h0;
      while (!fifo_ready) @(negedge clk);
    end
    @(negedge clk);
    fifo_valid = 1'b0;
    fifo_last  = 1'b0;
    t = 0;
    while (!irq_done && t < 2000) begin @(negedge clk); t++; end
    chk(irq_done, "R10", "completion pulse seen", 32'(irq_done), 32'd1);
    chk(irq_err == ((e != 0) || (len > MAXF)), "R10", "error pulse", 32'(irq_err),
        32'((e != 0) || (len > MAXF)));
    @(negedge clk);
    chk(!irq_done, "R10", "completion pulse width", 32'(irq_done), 32'd0);
    st = rd(DESC_BASE + 32'(8 * idx));
    chk(st[27:16] == 12'((len > 4095) ? 4095 : len), "R5", "length field",
        32'(st[27:16]), 32'((len > 4095) ? 4095 : len));
    chk(st[15:12] == {3'b011, idx == RING_N - 1}, "R8", "own/eop/sop/wrap at expected index",
        32'(st[15:12]), 32'({3'b011, idx == RING_N - 1}));
    exp_err = (32'(e[3]) << 9) | (32'(e[2]) << 2) | (32'(e[1]) << 1) | 32'(e[0]);
    chk({st[31:28], st[9:5], st[3:0]} == {4'h0, exp_err[9:5], exp_err[3:0]}, "R6",
        "error bits", st & 32'hF000_03EF, exp_err);
    chk(st[4] == (len > MAXF), "R7", "oversize bit", 32'(st[4]), 32'(len > MAXF));
    b = BUF_BASE + 32'(idx * 32'h1000);
    bad = 0;
    for (int w = 0; w < nw; w++) begin
      logic [31:0] ew;
      ew = '0;
      for (int j = 0; j < 4; j++)
        if (4 * w + j < len) ew[8 * j +: 8] = bval(len, 4 * w + j);
      if (rd(b + 32'(4 * w)) != ew) bad++;
    end
    chk(bad == 0, "R3", "data words mismatching", 32'(bad), 32'd0);
    chk(words_left == 0, "R4", "words left after bursts", 32'(words_left), 32'd0);
    if (len > BUF_BYTES)
      chk(!mem.exists(b + 32'(BUF_BYTES)), "R9", "write past buffer", rd(b + 32'(BUF_BYTES)), 32'hDEAD_BEEF);
    arm(idx, 1'b1);
  endtask

  initial begin
    int idx;
    int big [13] = '{63, 64, 65, 127, 128, 129, 2045, 2046, 2047, 2048, 4095, 4096, 4200};
    arm(0, 1'b0);
    for (int i = 1; i < RING_N; i++) arm(i, 1'b1);
    repeat (3) @(negedge clk);
    chk(!fifo_ready, "R11", "ready in reset", 32'(fifo_ready), 32'd0);
    chk(!irq_done && !irq_err, "R10", "irqs in reset", {30'd0, irq_done, irq_err}, 32'd0);
    chk(mem_req && !mem_we && mem_addr == DESC_BASE, "R1", "first access address", mem_addr, DESC_BASE);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    chk(!mem_req, "R2", "quiet while not owned", 32'(mem_req), 32'd0);
    chk(rd_count == 1, "R2", "polls before kick", 32'(rd_count), 32'd1);
    chk(!fifo_ready, "R11", "ready while stalled", 32'(fifo_ready), 32'd0);
    arm(0, 1'b1);
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    repeat (6) @(negedge clk);
    chk(rd_count == 3, "R2", "same index re-read after kick", 32'(rd_count), 32'd3);
    idx = 0;
    for (int len = 1; len <= 40; len++) begin
      run_frame(len, 4'(len), idx);
      idx = (idx + 1) % RING_N;
    end
    foreach (big[k]) begin
      run_frame(big[k], (big[k] == 4200) ? 4'b1010 : 4'b0000, idx);
      idx = (idx + 1) % RING_N;
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", "run did not complete", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule